// File: doc/BRIEF.md
# Spike-Timing Plasticity Weight Updater

This block is the learning engine for a bank of digital synapses in a spiking network. Each synapse has a stored weight of very few bits. The block also keeps, for each synapse, the time of its last presynaptic spike and the time of its last postsynaptic spike. Each new spike strobe names a synapse and is stamped with a shared wrapping time counter. The block compares that time with the stored time of the opposite spike type on the same synapse. When the two spikes are close enough, it adjusts the weight through read and write ports to an external synchronous weight memory.

A postsynaptic spike that arrives after a presynaptic one makes the connection stronger. A presynaptic spike that arrives after a postsynaptic one makes it weaker. The size of the step shrinks as the time gap grows. Beyond a proximity window nothing happens. Weights clamp at both ends of their code range. The weight width, the number of synapses, the counter width and the window are build parameters. Weight widths of 1, 2 and 4 bits are the intended settings.

Top module: `stdp_updater`

## Requirements
- R1: When `post_spk` alone arrives for a synapse and the gap d from that synapse's last presynaptic spike satisfies 0 < d < WIN, the stored weight increases by step(d). The result clamps at 2^WBITS-1.
- R2: When `pre_spk` alone arrives for a synapse and the gap d from that synapse's last postsynaptic spike satisfies 0 < d < WIN, the stored weight decreases by step(d). The result clamps at 0.
- R3: No weight write occurs in any of these cases: the gap is 0, the gap is WIN or more, or the opposite spike type has not been seen on that synapse since reset.
- R4: The step is step(d) = ceil((WIN-d)*SMAX/WIN). SMAX is floor((2^WBITS-1)/4) when WBITS >= 3, and 1 otherwise. With the defaults (WBITS=4, WIN=16) the step is 3 for d in 1..5, 2 for d in 6..10, and 1 for d in 11..15.
- R5: When `pre_spk` and `post_spk` arrive together on the same synapse, no weight write occurs. Both timestamps of that synapse take the value of `now`.
- R6: `wt_raddr` equals `syn_addr` in the spike cycle. The external memory returns the data one cycle later. The update is written, with `wt_we` high, in the cycle after the spike.
- R7: Gaps are computed modulo 2^TBITS, so a spike pair that straddles counter wraparound is still timed correctly.
- R8: Spikes in consecutive cycles on the same synapse each build on the result of the previous update, even though that update has not yet been committed in memory.
- R9: Reset holds `wt_we` low and marks every timestamp as unseen. Weights held in memory are kept across reset.
- R10: Every spike records its time for its own type on the named synapse, whether or not it causes a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_spk | input | 1 | Presynaptic spike strobe |
| post_spk | input | 1 | Postsynaptic spike strobe |
| syn_addr | input | AW | Synapse addressed by the strobes |
| now | input | TBITS | Free-running wrapping time counter |
| wt_raddr | output | AW | Weight memory read address |
| wt_rdata | input | WBITS | Weight memory read data, one cycle after the address |
| wt_we | output | 1 | Weight memory write enable |
| wt_waddr | output | AW | Weight memory write address |
| wt_wdata | output | WBITS | Weight memory write data |

## Verification
Two things can land in the same cycle: the write of one update, and the memory read issued for the next spike on the same synapse. The read then returns a stale weight, and the block must forward its own result instead. The bench provokes this by sending strobes on one synapse in back-to-back cycles. It does this in directed runs that climb into the top clamp and sink into the bottom clamp, and in a long random run over few synapses. Simultaneous pre and post strobes are the second kind of coincidence and are also mixed in. A behavioural model with its own weight array predicts the write in every cycle. The final memory contents must match the model's weights.

// File: rtl/stdp_updater.sv
module stdp_updater #(
  parameter int NSYN  = 8,
  parameter int WBITS = 4,
  parameter int TBITS = 8,
  parameter int WIN   = 16,
  localparam int AW   = (NSYN > 1) ? $clog2(NSYN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_spk,
  input  logic             post_spk,
  input  logic [AW-1:0]    syn_addr,
  input  logic [TBITS-1:0] now,
  output logic [AW-1:0]    wt_raddr,
  input  logic [WBITS-1:0] wt_rdata,
  output logic             wt_we,
  output logic [AW-1:0]    wt_waddr,
  output logic [WBITS-1:0] wt_wdata
);
  localparam int WMAX = (1 << WBITS) - 1;
  localparam int SMAX = (WBITS >= 3) ? WMAX / 4 : 1;
  localparam int DW   = $clog2(WIN);

  logic [WBITS-1:0] step_tab [WIN];
  for (genvar g = 0; g < WIN; g++) begin : g_step
    localparam int SV = (g == 0) ? 0 : ((WIN - g) * SMAX + WIN - 1) / WIN;
    assign step_tab[g] = WBITS'(SV);
  end

  logic [TBITS-1:0] pre_ts  [NSYN];
  logic [TBITS-1:0] post_ts [NSYN];
  logic [NSYN-1:0]  pre_seen, post_seen;

  wire only_pre  = pre_spk & ~post_spk;
  wire only_post = post_spk & ~pre_spk;

  wire [TBITS-1:0] other_ts   = only_pre ? post_ts[syn_addr] : pre_ts[syn_addr];
  wire             other_seen = only_pre ? post_seen[syn_addr] : pre_seen[syn_addr];
  wire [TBITS-1:0] dt         = now - other_ts;
  wire             in_win     = (only_pre | only_post) & other_seen &
                                (dt != '0) & (32'(dt) < WIN);

  logic             s1_v, s1_up, s1_fwd;
  logic [AW-1:0]    s1_addr;
  logic [WBITS-1:0] s1_step, s1_fdata;

  wire [WBITS-1:0] base   = s1_fwd ? s1_fdata : wt_rdata;
  wire [WBITS:0]   up_sum = {1'b0, base} + {1'b0, s1_step};
  wire [WBITS-1:0] up_res = up_sum[WBITS] ? WBITS'(WMAX) : up_sum[WBITS-1:0];
  wire [WBITS-1:0] dn_res = (base < s1_step) ? '0 : base - s1_step;

  assign wt_raddr = syn_addr;
  assign wt_we    = s1_v;
  assign wt_waddr = s1_addr;
  assign wt_wdata = s1_up ? up_res : dn_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_up    <= 1'b0;
      s1_fwd   <= 1'b0;
      s1_addr  <= '0;
      s1_step  <= '0;
      s1_fdata <= '0;
    end else begin
      s1_v     <= in_win;
      s1_up    <= only_post;
      s1_addr  <= syn_addr;
      s1_step  <= step_tab[dt[DW-1:0]];
      s1_fwd   <= s1_v & (s1_addr == syn_addr);
      s1_fdata <= wt_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_seen  <= '0;
      post_seen <= '0;
    end else begin
      if (pre_spk)  pre_seen[syn_addr]  <= 1'b1;
      if (post_spk) post_seen[syn_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pre_spk)  pre_ts[syn_addr]  <= now;
    if (post_spk) post_ts[syn_addr] <= now;
  end

  AST_WRITE_NEEDS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wt_we |-> $past(pre_spk ^ post_spk)); // R3
  AST_PAIR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_spk && post_spk) |=> !wt_we); // R5
  AST_UP_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_we && s1_up && base != WBITS'(WMAX)) |-> wt_wdata > base); // R1
  AST_DOWN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_we && !s1_up && base != '0) |-> wt_wdata < base); // R2
  AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wt_we |-> s1_step != '0); // R4
  AST_WRITE_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wt_we |-> wt_waddr == $past(syn_addr)); // R6
endmodule

// File: tb/tb_stdp_updater.sv
module tb_stdp_updater;
  localparam int NSYN = 8, WBITS = 4, TBITS = 8, WIN = 16, AW = 3;
  localparam int WMAX = (1 << WBITS) - 1;
  localparam int SMAX = (WBITS >= 3) ? WMAX / 4 : 1;

  logic clk = 0, rst_n = 0, pre_spk = 0, post_spk = 0;
  logic [AW-1:0] syn_addr = 0, wt_raddr, wt_waddr;
  logic [TBITS-1:0] now = 0;
  logic [WBITS-1:0] wt_rdata, wt_wdata;
  logic wt_we;
  logic [WBITS-1:0] mem [NSYN];

  always #5 clk = ~clk;

  stdp_updater #(.NSYN(NSYN), .WBITS(WBITS), .TBITS(TBITS), .WIN(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .pre_spk(pre_spk), .post_spk(post_spk),
    .syn_addr(syn_addr), .now(now), .wt_raddr(wt_raddr), .wt_rdata(wt_rdata),
    .wt_we(wt_we), .wt_waddr(wt_waddr), .wt_wdata(wt_wdata));

  always @(posedge clk) begin
    wt_rdata <= mem[wt_raddr];
    if (wt_we) mem[wt_waddr] <= wt_wdata;
  end

  int vectors = 0, fails = 0;
  int rw [NSYN], rpre [NSYN], rpost [NSYN];
  bit rpre_ok [NSYN], rpost_ok [NSYN];
  bit exp_we = 0;
  int exp_addr = 0, exp_data = 0;
  string exp_tag = "R9";

  task automatic check_cycle();
    vectors++;
    if (wt_we !== exp_we ||
        (exp_we && (int'(wt_waddr) != exp_addr || int'(wt_wdata) != exp_data))) begin
      fails++;
      $display("FAIL %s: we=%0b addr=%0d data=%0d expected we=%0b addr=%0d data=%0d",
               exp_tag, wt_we, wt_waddr, wt_wdata, exp_we, exp_addr, exp_data);
    end
  endtask

  task automatic model(input bit p, input bit q, input int a, input int t);
    int d, s, nw;
    bit ok;
    exp_we = 0;
    if (p ^ q) begin
      ok = p ? rpost_ok[a] : rpre_ok[a];
      d  = (t - (p ? rpost[a] : rpre[a])) & ((1 << TBITS) - 1);
      if (ok && d != 0 && d < WIN) begin
        s  = ((WIN - d) * SMAX + WIN - 1) / WIN;
        nw = q ? rw[a] + s : rw[a] - s;
        if (nw > WMAX) nw = WMAX;
        if (nw < 0) nw = 0;
        rw[a] = nw;
        exp_we = 1; exp_addr = a; exp_data = nw;
      end
    end
    if (p) begin rpre[a] = t; rpre_ok[a] = 1; end
    if (q) begin rpost[a] = t; rpost_ok[a] = 1; end
  endtask

  task automatic cyc(input bit p, input bit q, input int a, input int t, input string tag);
    @(negedge clk);
    check_cycle();
    pre_spk = p; post_spk = q; syn_addr = AW'(a); now = TBITS'(t);
    model(p, q, a, t & ((1 << TBITS) - 1));
    exp_tag = tag;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int t;
    for (int i = 0; i < NSYN; i++) begin
      mem[i] = WBITS'((i * 5 + 3) % 16); rw[i] = (i * 5 + 3) % 16;
      rpre_ok[i] = 0; rpost_ok[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_cycle(); // R9 reset state
    cyc(1, 0, 0, 10, "R3");  // no opposite spike seen yet
    cyc(0, 1, 0, 12, "R1");  // d=2, +3
    cyc(0, 0, 0, 13, "R6");
    cyc(1, 0, 0, 20, "R2");  // d=8, -2
    cyc(0, 1, 0, 35, "R4");  // d=15, +1
    cyc(0, 1, 0, 36, "R3");  // d=16, outside
    cyc(1, 0, 0, 36, "R3");  // d=0 after R10 timestamp refresh
    cyc(1, 1, 1, 40, "R5");
    cyc(0, 1, 1, 41, "R1");
    cyc(0, 1, 1, 42, "R8");
    cyc(0, 1, 1, 43, "R8");  // clamps at top
    cyc(1, 0, 1, 44, "R2");
    cyc(1, 0, 1, 45, "R8");
    cyc(0, 1, 6, 50, "R3");
    cyc(1, 0, 6, 51, "R2");  // clamps at zero
    cyc(1, 0, 3, 250, "R3");
    cyc(0, 1, 3, 259, "R7"); // wraps, d=9
    cyc(1, 0, 3, 259, "R10");
    cyc(0, 0, 0, 260, "R6");
    cyc(0, 0, 0, 260, "R6");
    @(negedge clk);
    check_cycle();
    rst_n = 0;
    for (int i = 0; i < NSYN; i++) begin rpre_ok[i] = 0; rpost_ok[i] = 0; end
    exp_we = 0; exp_tag = "R9";
    @(negedge clk);
    rst_n = 1;
    cyc(0, 1, 0, 5, "R9");   // timestamps forgotten
    cyc(1, 0, 0, 7, "R2");
    t = 7;
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      t = t + $urandom_range(0, 3);
      cyc(r == 0 || r == 1 || r == 4, r == 2 || r == 3 || r == 4,
          $urandom_range(0, 3), t, "R10");
    end
    cyc(0, 0, 0, t, "R8");
    cyc(0, 0, 0, t, "R8");
    @(negedge clk);
    for (int i = 0; i < NSYN; i++) begin
      vectors++;
      if (int'(mem[i]) != rw[i]) begin
        fails++;
        $display("FAIL R6: mem[%0d]=%0d expected %0d", i, mem[i], rw[i]);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule